// File: doc/BRIEF.md
# Storage Key Match Unit

This unit decides whether a single memory access may go ahead when protection is based on storage keys. Every page carries a 4-bit key and a fetch-protect flag. The running thread holds one 4-bit access key in its status word, so at any moment the thread belongs to exactly one key domain. A separate write port loads that key.

For each valid access, the unit compares the thread key with the page key. A thread key of zero is a master key and matches every page. A mismatch always blocks a store. A mismatch blocks a fetch only when the page's fetch-protect flag is set.

The verdict is registered. One cycle after a valid request, the unit raises either a grant pulse or a fault pulse. A fault also reports whether the blocked access was a store or a fetch. Page tables, key arrays and exception delivery sit outside this unit.

Top module: `skey_match_unit`

## Requirements
- R1: During and immediately after reset the thread key reads 0, and `grant`, `fault` and `fault_is_store` are all low.
- R2: When `key_wr_en` is high at a clock edge, `thread_key` takes `key_wr_data` on that edge. Without a write it holds its value.
- R3: When the thread key equals the page key, the access is granted, for both stores and fetches and whatever the fetch-protect flag says.
- R4: A store (`acc_is_store`=1) whose nonzero thread key differs from the page key raises `fault` with `fault_is_store`=1, whatever the fetch-protect flag says.
- R5: A fetch (`acc_is_store`=0) with a key mismatch is granted when `page_fprot`=0.
- R6: A fetch with a key mismatch raises `fault` with `fault_is_store`=0 when `page_fprot`=1.
- R7: A thread key of 0 grants every access, whatever the page key, the access type or the flag.
- R8: In the cycle after an edge where `acc_valid` is low, neither `grant` nor `fault` is asserted.
- R9: The verdict for a valid request appears on the clock edge after the request is sampled. Exactly one of `grant` or `fault` is high in that cycle, and they are never high together.
- R10: An access sampled on the same edge as a key write is judged with the key held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_wr_en | input | 1 | Load the thread key |
| key_wr_data | input | 4 | New thread key value |
| acc_valid | input | 1 | An access request is present this cycle |
| acc_is_store | input | 1 | 1 = store, 0 = fetch |
| page_key | input | 4 | Storage key of the addressed page |
| page_fprot | input | 1 | Page fetch-protect flag |
| thread_key | output | 4 | Current thread access key |
| grant | output | 1 | Registered: previous access allowed |
| fault | output | 1 | Registered: previous access blocked |
| fault_is_store | output | 1 | With `fault`: 1 if the blocked access was a store |

## Verification
The properties assume that the page key, the flag and the access type are stable and known whenever `acc_valid` is high at an edge. They also assume that the key shown on `thread_key` at that edge is the key the verdict must use. The bench changes every input only on falling edges and holds it for a full cycle, so each rising edge samples one well-defined request. Key writes are issued either alone or deliberately on the same edge as an access, to exercise the old-key rule.

// File: rtl/skey_match_unit.sv
module skey_match_unit #(
  parameter int KEY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_wr_en,
  input  logic [KEY_W-1:0] key_wr_data,
  input  logic             acc_valid,
  input  logic             acc_is_store,
  input  logic [KEY_W-1:0] page_key,
  input  logic             page_fprot,
  output logic [KEY_W-1:0] thread_key,
  output logic             grant,
  output logic             fault,
  output logic             fault_is_store
);

  localparam logic [KEY_W-1:0] MASTER_KEY = '0;

  logic key_hit;
  logic blocked;

  assign key_hit = (thread_key == MASTER_KEY) || (thread_key == page_key);
  assign blocked = !key_hit && (acc_is_store || page_fprot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      thread_key <= MASTER_KEY;
    else if (key_wr_en)
      thread_key <= key_wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant          <= 1'b0;
      fault          <= 1'b0;
      fault_is_store <= 1'b0;
    end else begin
      grant          <= acc_valid && !blocked;
      fault          <= acc_valid && blocked;
      fault_is_store <= acc_valid && blocked && acc_is_store;
    end
  end

endmodule

// File: rtl/skey_match_unit_sva.sv
module skey_match_unit_sva #(
  parameter int KEY_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             key_wr_en,
  input logic [KEY_W-1:0] key_wr_data,
  input logic             acc_valid,
  input logic             acc_is_store,
  input logic [KEY_W-1:0] page_key,
  input logic             page_fprot,
  input logic [KEY_W-1:0] thread_key,
  input logic             grant,
  input logic             fault,
  input logic             fault_is_store
);

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !grant && !fault && !fault_is_store); // R1
  AST_KEY_LOAD: assert property (@(posedge clk) disable iff (!rst_n) key_wr_en |=> thread_key == $past(key_wr_data)); // R2
  AST_KEY_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !key_wr_en |=> $stable(thread_key)); // R2
  AST_MATCH_GRANT: assert property (@(posedge clk) disable iff (!rst_n) acc_valid && thread_key == page_key |=> grant); // R3
  AST_STORE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_is_store && thread_key != '0 && thread_key != page_key |=> fault && fault_is_store); // R4
  AST_FETCH_OPEN: assert property (@(posedge clk) disable iff (!rst_n) acc_valid && !acc_is_store && !page_fprot |=> grant); // R5
  AST_FETCH_PROT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_is_store && page_fprot && thread_key != '0 && thread_key != page_key |=> fault && !fault_is_store); // R6
  AST_MASTER_KEY: assert property (@(posedge clk) disable iff (!rst_n) acc_valid && thread_key == '0 |=> grant); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !acc_valid |=> !grant && !fault); // R8
  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n) acc_valid |=> grant != fault); // R9
  AST_NO_BOTH: assert property (@(posedge clk) disable iff (!rst_n) !(grant && fault)); // R9
  AST_TYPE_GATED: assert property (@(posedge clk) disable iff (!rst_n) fault_is_store |-> fault); // R4

endmodule

bind skey_match_unit skey_match_unit_sva #(.KEY_W(KEY_W)) u_skey_match_unit_sva (
  .clk(clk), .rst_n(rst_n), .key_wr_en(key_wr_en), .key_wr_data(key_wr_data),
  .acc_valid(acc_valid), .acc_is_store(acc_is_store), .page_key(page_key),
  .page_fprot(page_fprot), .thread_key(thread_key), .grant(grant),
  .fault(fault), .fault_is_store(fault_is_store)
);

// File: tb/test_skey_match_unit.sv
module test_skey_match_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       key_wr_en = 1'b0;
  logic [3:0] key_wr_data = '0;
  logic       acc_valid = 1'b0;
  logic       acc_is_store = 1'b0;
  logic [3:0] page_key = '0;
  logic       page_fprot = 1'b0;
  logic [3:0] thread_key;
  logic       grant, fault, fault_is_store;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  skey_match_unit i_skey_match_unit (
    .clk(clk), .rst_n(rst_n), .key_wr_en(key_wr_en), .key_wr_data(key_wr_data),
    .acc_valid(acc_valid), .acc_is_store(acc_is_store), .page_key(page_key),
    .page_fprot(page_fprot), .thread_key(thread_key), .grant(grant),
    .fault(fault), .fault_is_store(fault_is_store)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_key(logic [3:0] k);
    @(negedge clk);
    key_wr_en = 1'b1; key_wr_data = k;
    @(negedge clk);
    key_wr_en = 1'b0;
    check("R2 key load", thread_key, k);
  endtask

  task automatic access(string req, logic st, logic [3:0] pk, logic fp,
                        logic exp_grant, logic exp_store_fault);
    @(negedge clk);
    acc_valid = 1'b1; acc_is_store = st; page_key = pk; page_fprot = fp;
    @(negedge clk);
    acc_valid = 1'b0;
    check({req, " grant"}, grant, exp_grant);
    check({req, " fault"}, fault, !exp_grant);
    check({req, " fault_is_store"}, fault_is_store, !exp_grant && exp_store_fault);
  endtask

  task automatic t_reset;
    #3;
    check("R1 key in reset", thread_key, 0);
    check("R1 grant in reset", grant, 0);
    check("R1 fault in reset", fault, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 key after reset", thread_key, 0);
    check("R8 idle grant", grant, 0);
    check("R8 idle fault", fault, 0);
  endtask

  task automatic t_master;
    access("R7 store", 1'b1, 4'd9, 1'b1, 1'b1, 1'b0);
    access("R7 fetch", 1'b0, 4'd15, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_match;
    set_key(4'd6);
    access("R3 store", 1'b1, 4'd6, 1'b0, 1'b1, 1'b0);
    access("R3 fetch prot", 1'b0, 4'd6, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_mismatch;
    access("R4 store noprot", 1'b1, 4'd7, 1'b0, 1'b0, 1'b1);
    access("R4 store prot", 1'b1, 4'd0, 1'b1, 1'b0, 1'b1);
    access("R5 fetch noprot", 1'b0, 4'd3, 1'b0, 1'b1, 1'b0);
    access("R6 fetch prot", 1'b0, 4'd3, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    acc_is_store = 1'b1; page_key = 4'd1; page_fprot = 1'b1;
    @(negedge clk);
    check("R8 idle grant", grant, 0);
    check("R8 idle fault", fault, 0);
    check("R9 pulse ends", fault_is_store, 0);
  endtask

  task automatic t_same_edge;
    set_key(4'd5);
    @(negedge clk);
    key_wr_en = 1'b1; key_wr_data = 4'd9;
    acc_valid = 1'b1; acc_is_store = 1'b1; page_key = 4'd5; page_fprot = 1'b0;
    @(negedge clk);
    key_wr_en = 1'b0; acc_valid = 1'b0;
    check("R10 old key grant", grant, 1);
    check("R10 old key fault", fault, 0);
    check("R2 new key", thread_key, 9);
    access("R10 new key store", 1'b1, 4'd5, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_back_to_back;
    set_key(4'd12);
    @(negedge clk);
    acc_valid = 1'b1; acc_is_store = 1'b1; page_key = 4'd12; page_fprot = 1'b0;
    @(negedge clk);
    check("R9 first grant", grant, 1);
    acc_is_store = 1'b0; page_key = 4'd2; page_fprot = 1'b1;
    @(negedge clk);
    acc_valid = 1'b0;
    check("R9 second fault", fault, 1);
    check("R9 second grant", grant, 0);
    check("R6 second type", fault_is_store, 0);
  endtask

  initial begin
    t_reset;
    t_master;
    t_match;
    t_mismatch;
    t_idle;
    t_same_edge;
    t_back_to_back;
    set_key(4'd0);
    access("R7 after reload", 1'b1, 4'd4, 1'b0, 1'b1, 1'b0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule